// File: doc/BRIEF.md
# Banked Status Register Access Unit

This unit holds a processor's live status word and five saved copies of it, one per exception mode that has its own register bank. It serves two instruction-level operations: a status read, which returns the live word or the current mode's saved copy on a general result bus, and a status write, which takes a register value or an expanded 8-bit immediate and updates only the byte fields chosen by a four-bit mask. Every write is filtered by the current privilege level, and some bits are protected outright.

A separate exception-entry strobe stores the live word into the saved copy of the target mode, switches to that mode and masks IRQs, all on one clock edge. The mode, the two interrupt-mask bits and the four condition flags are brought out as dedicated outputs. Fetch, decode and the register file sit outside this unit.

Top module: `psr_unit`

## Requirements
- R1: After a synchronous active-low reset the live word reads 0x000000D3 (supervisor mode 0x13, IRQ mask bit 7 and FIQ mask bit 6 set, flags clear), and every saved copy reads zero.
- R2: The word is four byte fields; `wr_fields` bit k enables bits [8k+7:8k]. Bytes whose enable is low keep their value.
- R3: `rd_data` shows the live word when `rd_saved` is 0, and the saved copy of the current mode when it is 1. The read is combinational and shows the state left by the last clock edge.
- R4: In user mode (0x10) a live-word write changes only the flag byte [31:24]. Enables for the other three bytes are ignored.
- R5: User mode and system mode (0x1F) have no saved copy. A saved read there returns zero. A saved write there changes nothing.
- R6: With `wr_use_imm` set, the operand is `wr_imm` zero-extended to 32 bits and rotated right by twice `wr_rot` (0 to 30 bit positions).
- R7: The mode sits in bits [4:0]. Bit 7 is the IRQ mask and bit 6 is the FIQ mask. A control-byte write that changes only the mode bits leaves both masks as they were read.
- R8: Bit 5 (compact instruction state) and bit 24 (bytecode state) never change through a status write, whether to the live word or to a saved copy.
- R9: A control-byte write whose bits [4:0] are not one of 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B or 0x1F keeps the old mode. The other written bits still take effect.
- R10: The five saved copies (FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B) are independent. A write reaches only the current mode's copy.
- R11: When `exc_en` is high with a banked `exc_mode`, the target's saved copy receives the live word as it was before the edge, the mode becomes `exc_mode`, and bit 7 is set. The flags and bit 6 are left alone. A non-banked target is ignored.
- R12: When an exception entry and a status write fall in the same cycle, the entry wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Status write strobe |
| wr_saved | input | 1 | Write target: 0 live word, 1 saved copy of current mode |
| wr_use_imm | input | 1 | Operand select: 1 expanded immediate, 0 register value |
| wr_reg | input | 32 | Register operand |
| wr_imm | input | 8 | Immediate byte |
| wr_rot | input | 4 | Immediate rotate count (times two) |
| wr_fields | input | 4 | Per-byte write enables |
| rd_saved | input | 1 | Read source: 0 live word, 1 saved copy of current mode |
| rd_data | output | 32 | Read result |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception entry |
| mode | output | 5 | Current mode |
| irq_masked | output | 1 | IRQ mask bit |
| fiq_masked | output | 1 | FIQ mask bit |
| flags | output | 4 | Condition flags, bits [31:28] |

## Verification
An exception entry and a status write can land on the same edge. The entry's capture of the live word and its change of mode then compete with the write's update of either the live word or the saved copy. The bench drives both strobes together on purpose, with writes aimed at the live word and at the saved copy. It also raises them together at random during a long mixed run. Each outcome is judged against a behavioural model that applies the entry and drops the write, and the saved copy is read back after a later mode switch.

// File: rtl/psr_pkg.sv
// psr_pkg: shared widths, bit positions, mode codes and helper functions
// for the banked status register unit. Assumes a 32-bit word of 8-bit fields.
package psr_pkg;
    localparam int WORD_W     = 32;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = WORD_W / FIELD_W;
    localparam int MODE_W     = 5;
    localparam int IMM_W      = 8;
    localparam int ROT_W      = 4;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS + 1);

    localparam int BIT_IRQ    = 7;
    localparam int BIT_FIQ    = 6;
    localparam int BIT_CSTATE = 5;
    localparam int BIT_BSTATE = 24;
    localparam int FLAG_LSB   = 28;

    localparam logic [MODE_W-1:0] M_USR = 5'h10;
    localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] M_SVC = 5'h13;
    localparam logic [MODE_W-1:0] M_ABT = 5'h17;
    localparam logic [MODE_W-1:0] M_UND = 5'h1B;
    localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

    localparam logic [BANK_IDX_W-1:0] NO_BANK     = '1;
    localparam logic [NUM_FIELDS-1:0] USER_FIELDS = NUM_FIELDS'(1) << (NUM_FIELDS - 1);
    localparam logic [WORD_W-1:0]     RESET_WORD  =
        WORD_W'(M_SVC) | (WORD_W'(1) << BIT_IRQ) | (WORD_W'(1) << BIT_FIQ);

    // Map a mode code to its saved-copy slot, NO_BANK when it has none.
    function automatic logic [BANK_IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            M_FIQ:   bank_of = BANK_IDX_W'(0);
            M_IRQ:   bank_of = BANK_IDX_W'(1);
            M_SVC:   bank_of = BANK_IDX_W'(2);
            M_ABT:   bank_of = BANK_IDX_W'(3);
            M_UND:   bank_of = BANK_IDX_W'(4);
            default: bank_of = NO_BANK;
        endcase
    endfunction

    // True for the seven defined mode codes.
    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        mode_legal = (bank_of(m) != NO_BANK) || (m == M_USR) || (m == M_SYS);
    endfunction
endpackage

// File: rtl/psr_imm_expand.sv
// psr_imm_expand: widens an immediate byte to a full word and rotates it
// right by twice the rotate field. Purely combinational.
module psr_imm_expand
    import psr_pkg::*;
(
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    output logic [WORD_W-1:0] word
);
    localparam int SH_W = ROT_W + 1;

    logic [SH_W-1:0]     shift;
    logic [2*WORD_W-1:0] doubled;

    // Rotate by shifting a doubled copy and keeping the low half.
    always_comb begin
        shift   = {rot, 1'b0};
        doubled = {WORD_W'(imm), WORD_W'(imm)} >> shift;
        word    = doubled[WORD_W-1:0];
    end

    // A zero rotate passes the byte through unchanged.
    always_comb begin
        if (rot == '0) begin
            p_no_rot_passthru_r6: assert (word == WORD_W'(imm));
        end
    end
endmodule

// File: rtl/psr_field_merge.sv
// psr_field_merge: combines an old status word with an operand byte by byte
// under a field enable. The two execution-state bits always come from the
// old word, and an illegal mode code is replaced by the old mode.
module psr_field_merge
    import psr_pkg::*;
(
    input  logic [WORD_W-1:0]     old_word,
    input  logic [WORD_W-1:0]     new_word,
    input  logic [NUM_FIELDS-1:0] field_en,
    output logic [WORD_W-1:0]     merged
);
    logic [WORD_W-1:0] by_field;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign by_field[g*FIELD_W +: FIELD_W] =
            field_en[g] ? new_word[g*FIELD_W +: FIELD_W] : old_word[g*FIELD_W +: FIELD_W];
    end

    // Restore protected bits and reject undefined mode codes.
    always_comb begin
        merged             = by_field;
        merged[BIT_CSTATE] = old_word[BIT_CSTATE];
        merged[BIT_BSTATE] = old_word[BIT_BSTATE];
        if (!mode_legal(by_field[MODE_W-1:0])) begin
            merged[MODE_W-1:0] = old_word[MODE_W-1:0];
        end
    end
endmodule

// File: rtl/psr_saved_bank.sv
// psr_saved_bank: one saved status word per banked exception mode, with a
// single write port and a single combinational read port. Assumes the
// caller gives at most one write per cycle. An out-of-range index reads zero.
module psr_saved_bank
    import psr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BANK_IDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [BANK_IDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0]     rd_data
);
    logic [WORD_W-1:0] slot_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
        // Hold or load this mode's saved word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == BANK_IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end

        // A slot that is not addressed keeps its content.
        p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == BANK_IDX_W'(g))) |=> $stable(slot_q[g]));
    end

    // Select the addressed slot, zero when none matches.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (rd_idx == BANK_IDX_W'(i)) rd_data = slot_q[i];
        end
    end
endmodule

// File: rtl/psr_unit.sv
// psr_unit: live status word plus banked saved copies. Serves status reads,
// masked status writes from a register or an expanded immediate, and
// exception entry. An exception entry takes priority over a write in the
// same cycle. Assumes the caller raises each strobe for one cycle per operation.
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_saved,
    input  logic              wr_use_imm,
    input  logic [31:0]       wr_reg,
    input  logic [7:0]        wr_imm,
    input  logic [3:0]        wr_rot,
    input  logic [3:0]        wr_fields,
    input  logic              rd_saved,
    output logic [31:0]       rd_data,
    input  logic              exc_en,
    input  logic [4:0]        exc_mode,
    output logic [4:0]        mode,
    output logic              irq_masked,
    output logic              fiq_masked,
    output logic [3:0]        flags
);
    logic [WORD_W-1:0]     live_q;
    logic [WORD_W-1:0]     live_d;
    logic [WORD_W-1:0]     imm_word;
    logic [WORD_W-1:0]     operand;
    logic [WORD_W-1:0]     live_merged;
    logic [WORD_W-1:0]     saved_rd;
    logic [WORD_W-1:0]     saved_merged;
    logic [WORD_W-1:0]     bank_wdata;
    logic [BANK_IDX_W-1:0] cur_idx;
    logic [BANK_IDX_W-1:0] exc_idx;
    logic [BANK_IDX_W-1:0] bank_widx;
    logic [NUM_FIELDS-1:0] live_fields;
    logic                  cur_banked;
    logic                  exc_take;
    logic                  in_user;
    logic                  bank_we;

    psr_imm_expand u_imm (
        .imm  (wr_imm),
        .rot  (wr_rot),
        .word (imm_word)
    );

    // Decode the current mode, the exception target and the allowed fields.
    always_comb begin
        operand     = wr_use_imm ? imm_word : wr_reg;
        cur_idx     = bank_of(live_q[MODE_W-1:0]);
        cur_banked  = (cur_idx != NO_BANK);
        exc_idx     = bank_of(exc_mode);
        exc_take    = exc_en && (exc_idx != NO_BANK);
        in_user     = (live_q[MODE_W-1:0] == M_USR);
        live_fields = wr_fields & (in_user ? USER_FIELDS : '1);
    end

    psr_field_merge u_merge_live (
        .old_word (live_q),
        .new_word (operand),
        .field_en (live_fields),
        .merged   (live_merged)
    );

    psr_field_merge u_merge_saved (
        .old_word (saved_rd),
        .new_word (operand),
        .field_en (wr_fields),
        .merged   (saved_merged)
    );

    psr_saved_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .wr_idx  (bank_widx),
        .wr_data (bank_wdata),
        .rd_idx  (cur_idx),
        .rd_data (saved_rd)
    );

    // Pick the saved-copy write: an exception capture first, then a status write.
    always_comb begin
        bank_we    = 1'b0;
        bank_widx  = cur_idx;
        bank_wdata = saved_merged;
        if (exc_take) begin
            bank_we    = 1'b1;
            bank_widx  = exc_idx;
            bank_wdata = live_q;
        end else if (wr_en && wr_saved && cur_banked) begin
            bank_we = 1'b1;
        end
    end

    // Next live word: exception entry beats a status write.
    always_comb begin
        live_d = live_q;
        if (exc_take) begin
            live_d[MODE_W-1:0] = exc_mode;
            live_d[BIT_IRQ]    = 1'b1;
        end else if (wr_en && !wr_saved) begin
            live_d = live_merged;
        end
    end

    // Live status register.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= RESET_WORD;
        else        live_q <= live_d;
    end

    // Drive the read bus and the decoded outputs.
    always_comb begin
        if (!rd_saved)       rd_data = live_q;
        else if (cur_banked) rd_data = saved_rd;
        else                 rd_data = '0;
        mode       = live_q[MODE_W-1:0];
        irq_masked = live_q[BIT_IRQ];
        fiq_masked = live_q[BIT_FIQ];
        flags      = live_q[WORD_W-1:FLAG_LSB];
    end

    // In user mode, with no exception, only the flag byte can move.
    p_user_ctrl_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_user && !exc_en) |=> $stable(live_q[WORD_W-FIELD_W-1:0]));

    // Without an exception entry the two execution-state bits never change.
    p_state_bits_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take |=> $stable({live_q[BIT_BSTATE], live_q[BIT_CSTATE]}));

    // The mode field always holds a defined code.
    p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> mode_legal(mode));

    // Exception entry lands on its target mode with IRQs masked.
    p_exc_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (mode == $past(exc_mode)) && irq_masked);

    // A write in the same cycle as an entry leaves the flags untouched.
    p_exc_beats_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && wr_en) |=> (flags == $past(flags)));

    // No saved copy in user or system mode reads as zero.
    p_no_bank_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_saved && !cur_banked) |-> (rd_data == '0));
endmodule

// File: tb/psr_unit_tb.sv
// psr_unit_tb: directed and random stimulus against a behavioural model
// of the status unit, compared after every clock.
module psr_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_OPS   = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_saved, wr_use_imm, rd_saved, exc_en;
    logic [31:0] wr_reg;
    logic [7:0]  wr_imm;
    logic [3:0]  wr_rot, wr_fields;
    logic [4:0]  exc_mode;
    logic [31:0] rd_data;
    logic [4:0]  mode;
    logic        irq_masked, fiq_masked;
    logic [3:0]  flags;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] m_live;
    logic [31:0] m_saved [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_saved(wr_saved),
        .wr_use_imm(wr_use_imm), .wr_reg(wr_reg), .wr_imm(wr_imm),
        .wr_rot(wr_rot), .wr_fields(wr_fields), .rd_saved(rd_saved),
        .rd_data(rd_data), .exc_en(exc_en), .exc_mode(exc_mode),
        .mode(mode), .irq_masked(irq_masked), .fiq_masked(fiq_masked),
        .flags(flags)
    );

    function automatic int slot(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic bit legal(input logic [4:0] m);
        return (slot(m) >= 0) || (m == 5'h10) || (m == 5'h1F);
    endfunction

    function automatic logic [31:0] rotr(input logic [7:0] b, input logic [3:0] r);
        logic [31:0] v = {24'd0, b};
        for (int k = 0; k < 2 * r; k++) v = {v[0], v[31:1]};
        return v;
    endfunction

    function automatic logic [31:0] mix(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] en);
        logic [31:0] res = old;
        for (int f = 0; f < 4; f++) if (en[f]) res[f*8 +: 8] = nw[f*8 +: 8];
        if (en[0] && !legal(nw[4:0])) res[4:0] = old[4:0];
        res[5]  = old[5];
        res[24] = old[24];
        return res;
    endfunction

    function automatic logic [31:0] model_read(input logic rs);
        int s = slot(m_live[4:0]);
        if (!rs) return m_live;
        return (s >= 0) ? m_saved[s] : 32'd0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model one clock edge from the driven inputs.
    task automatic model_edge();
        int ts = slot(exc_mode);
        int cs = slot(m_live[4:0]);
        logic [31:0] op = wr_use_imm ? rotr(wr_imm, wr_rot) : wr_reg;
        if (exc_en && ts >= 0) begin
            m_saved[ts] = m_live;
            m_live[4:0] = exc_mode;
            m_live[7]   = 1'b1;
        end else if (wr_en) begin
            if (wr_saved) begin
                if (cs >= 0) m_saved[cs] = mix(m_saved[cs], op, wr_fields);
            end else begin
                m_live = mix(m_live, op, (m_live[4:0] == 5'h10) ? (wr_fields & 4'b1000) : wr_fields);
            end
        end
    endtask

    // Apply one cycle of stimulus at the falling edge and compare.
    task automatic step(input bit we, input bit ws, input bit ui, input logic [31:0] rg,
                        input logic [7:0] im, input logic [3:0] ro, input logic [3:0] fm,
                        input bit rs, input bit ee, input logic [4:0] em, input string tag);
        wr_en = we; wr_saved = ws; wr_use_imm = ui; wr_reg = rg; wr_imm = im;
        wr_rot = ro; wr_fields = fm; rd_saved = rs; exc_en = ee; exc_mode = em;
        #1;
        chk(tag, "read before edge", rd_data, model_read(rs));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "read after edge", rd_data, model_read(rs));
        chk(tag, "mode", {27'd0, mode}, {27'd0, m_live[4:0]});
        chk(tag, "masks", {30'd0, irq_masked, fiq_masked}, {30'd0, m_live[7], m_live[6]});
        chk(tag, "flags", {28'd0, flags}, {28'd0, m_live[31:28]});
    endtask

    task automatic idle_read(input bit rs, input string tag);
        step(0, 0, 0, 32'd0, 8'd0, 4'd0, 4'd0, rs, 0, 5'd0, tag);
    endtask

    task automatic wreg(input bit ws, input logic [31:0] v, input logic [3:0] fm, input string tag);
        step(1, ws, 0, v, 8'd0, 4'd0, fm, ws, 0, 5'd0, tag);
    endtask

    task automatic enter(input logic [4:0] m, input string tag);
        step(0, 0, 0, 32'd0, 8'd0, 4'd0, 4'd0, 1, 1, m, tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog R1..all actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [4:0] pick [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        rst_n = 1'b0;
        wr_en = 0; wr_saved = 0; wr_use_imm = 0; wr_reg = 0; wr_imm = 0;
        wr_rot = 0; wr_fields = 0; rd_saved = 0; exc_en = 0; exc_mode = 0;
        m_live = 32'h0000_00D3;
        for (int i = 0; i < 5; i++) m_saved[i] = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values.
        #1;
        chk("R1", "live word", rd_data, 32'h0000_00D3);
        chk("R1", "mode", {27'd0, mode}, 32'h13);
        chk("R1", "masks", {30'd0, irq_masked, fiq_masked}, 32'h3);
        chk("R1", "flags", {28'd0, flags}, 32'h0);
        rd_saved = 1'b1; #1;
        chk("R1", "saved copy", rd_data, 32'd0);

        // R6: immediate 0xF0 rotated by 8 sets all flags.
        step(1, 0, 1, 32'd0, 8'hF0, 4'd4, 4'b1000, 0, 0, 5'd0, "R6");
        chk("R6", "literal", rd_data, 32'hF000_00D3);
        step(1, 0, 1, 32'd0, 8'hAB, 4'd15, 4'b0110, 0, 0, 5'd0, "R6");
        // R2: middle two bytes from a register.
        wreg(0, 32'h11BB_CC13, 4'b0110, "R2");
        // R7: read-modify-write of the mode only.
        wreg(0, (m_live & ~32'h1F) | 32'h12, 4'b0001, "R7");
        chk("R7", "irq mode kept masks", {rd_data[7:6], 1'b0, rd_data[4:0]}, 8'hD2);
        // R8: protected state bits in flag and control bytes.
        wreg(0, 32'h0100_0032, 4'b1001, "R8");
        chk("R8", "bits 24 and 5", {30'd0, rd_data[24], rd_data[5]}, 32'd0);
        // R9: undefined mode code.
        wreg(0, 32'h0000_00C5, 4'b0001, "R9");
        // R10: saved writes in each banked mode, then read back.
        for (int i = 1; i < 6; i++) begin
            wreg(0, {27'd0, pick[i]} | 32'hC0, 4'b0001, "R10");
            wreg(1, 32'h1234_5600 | i * 32'h0101_0000 | {27'd0, pick[(i % 5) + 1]}, 4'b1111, "R10");
        end
        for (int i = 1; i < 6; i++) begin
            wreg(0, {27'd0, pick[i]} | 32'hC0, 4'b0001, "R10");
            idle_read(1, "R10");
        end
        // R11: exception entries to every banked mode and to a non-banked one.
        wreg(0, 32'h5000_0013, 4'b1001, "R11");
        for (int i = 1; i < 6; i++) enter(pick[i], "R11");
        enter(5'h10, "R11");
        enter(5'h1F, "R11");
        // R12: entry together with a live write and with a saved write.
        step(1, 0, 0, 32'hA000_0010, 8'd0, 4'd0, 4'b1111, 1, 1, 5'h17, "R12");
        step(1, 1, 0, 32'hFFFF_FF1B, 8'd0, 4'd0, 4'b1111, 1, 1, 5'h13, "R12");
        wreg(0, 32'h0000_00D7, 4'b0001, "R12");
        idle_read(1, "R12");
        // R4: drop to user, then try every field.
        wreg(0, 32'h0000_0010, 4'b0001, "R4");
        wreg(0, 32'h9000_00D3, 4'b1111, "R4");
        step(1, 0, 1, 32'd0, 8'hFF, 4'd0, 4'b0001, 0, 0, 5'd0, "R4");
        // R5: user has no saved copy.
        wreg(1, 32'hDEAD_BEEF, 4'b1111, "R5");
        idle_read(1, "R5");
        // R5: system mode via an entry and a write.
        enter(5'h13, "R5");
        wreg(0, 32'h0000_00DF, 4'b0001, "R5");
        wreg(1, 32'hCAFE_F00D, 4'b1111, "R5");
        idle_read(1, "R5");
        wreg(0, 32'h0000_00D3, 4'b0001, "R5");
        idle_read(1, "R5");

        // R3: long random mix of reads, writes and entries.
        for (int n = 0; n < RAND_OPS; n++) begin
            logic [31:0] rg = $urandom;
            logic [4:0]  em = pick[$urandom_range(0, 6)];
            if ($urandom_range(0, 7) != 0) rg[4:0] = pick[$urandom_range(0, 6)];
            step($urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                 rg, 8'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
                 $urandom_range(0, 9) == 0, ($urandom_range(0, 7) == 0) ? 5'h05 : em, "R3");
        end

        summary();
        $finish;
    end
endmodule